// File: doc/BRIEF.md
# Trap Instruction Transformer

This combinational block produces the instruction word reported to a trap handler when a guest memory access faults. It takes the faulting instruction (16-bit compressed or 32-bit), the faulting address and the current register-width mode (32 or 64). It names the base register of the access on an index output and takes that register's value back from a register-file read port. From these it forms a report word. In that word the immediate is zero, the rs1 field carries the byte offset of the fault inside the access, and bit 1 is cleared when the source was compressed.

Compressed loads and stores from quadrants 0 and 2 are expanded to their 32-bit equivalents. The 32-bit loads and stores, atomic memory operations and hypervisor virtual-machine loads and stores keep their other fields. Anything else reports zero. The handler uses the word to emulate or retry the access without fetching the instruction itself.

Top module: `trap_insn_xform`

## Requirements
- R1: A word whose bits [1:0] are not 2'b11 is treated as compressed. Only quadrant 0 (bits [1:0]=00) and quadrant 2 (bits [1:0]=10) are expanded. Any other compressed word gives tinst_o = 0 and base_idx_o = 0.
- R2: Compressed word load (quadrant 0, bits [15:13]=010) expands to opcode 0000011 with funct3 010. Compressed word store (bits [15:13]=110) expands to opcode 0100011 with funct3 010. The 3-bit register field [4:2] plus 8 goes to rd [11:7] for loads and to rs2 [24:20] for stores. The base index is field [9:7] plus 8, and the access size is 4.
- R3: The shared compressed codes (bits [15:13]=011 load, 111 store, in both quadrants) expand differently by mode. With rv32_i=1 they become the single-precision FP form (load opcode 0000111, store opcode 0100111, funct3 010, size 4). With rv32_i=0 they become the doubleword integer form (funct3 011, size 8).
- R4: The compressed double-precision FP load (bits [15:13]=001) and store (bits [15:13]=101) expand in either mode to opcodes 0000111 and 0100111 with funct3 011 and size 8.
- R5: The stack-relative forms in quadrant 2 use register 2 as base (base_idx_o = 2). Loads take rd from field [11:7], and stores take rs2 from field [6:2].
- R6: For a compressed source, bit 1 of tinst_o is 0.
- R7: For 32-bit load (0000011) and FP-load (0000111) opcodes, bits [31:20] of tinst_o are zero. All other fields are kept except rs1, and the size is 1 << funct3.
- R8: For 32-bit store (0100011) and FP-store (0100111) opcodes, bits [31:25] and [11:7] of tinst_o are zero. All other fields are kept except rs1, and the size is 1 << funct3.
- R9: Atomic memory operations (opcode 0101111) pass through unchanged except for rs1. The size is 1 << funct3.
- R10: The hypervisor virtual load/store encoding (opcode 1110011, funct3 100) passes through unchanged except for rs1. The size is 1 << (1 << insn[27:26]).
- R11: For any access with a size, base_idx_o names the base register (bits [19:15] for 32-bit forms). Bits [19:15] of tinst_o become the low five bits of (fault_addr_i − (base_val_i + imm)) & (size − 1). Here imm is the sign-extended 32-bit immediate, or the scaled zero-extended compressed immediate, and is 0 for atomic and hypervisor forms.
- R12: Any 32-bit opcode not listed above, including system instructions with funct3 other than 100, gives tinst_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Faulting instruction; a compressed word sits in [15:0] |
| rv32_i | input | 1 | 1 selects 32-bit register mode, 0 selects 64-bit |
| fault_addr_i | input | AW | Faulting virtual address |
| base_val_i | input | AW | Value of the register named by base_idx_o |
| base_idx_o | output | 5 | Index of the access's base register |
| tinst_o | output | 32 | Transformed instruction word |

## Verification
The offset field only carries information when the faulting address is misaligned with respect to the access size. The field mask is also very different per form: for the hypervisor encoding the size grows as a double power of two and reaches 256. The stimulus therefore pairs each instruction with a base value and a fault address chosen so that the expected offset is nonzero and differs between candidate sizes. For example, an address 5 bytes past base plus immediate gives 1 for a word access and 5 for a doubleword. Mode-dependent compressed codes are driven in both modes with the same address, so a wrong size or a wrong opcode shows as a different report.

// File: rtl/trap_insn_xform.sv
`timescale 1ns/1ps
module trap_insn_xform #(
  parameter int AW = 64
) (
  input  logic [31:0]   insn_i,
  input  logic          rv32_i,
  input  logic [AW-1:0] fault_addr_i,
  input  logic [AW-1:0] base_val_i,
  output logic [4:0]    base_idx_o,
  output logic [31:0]   tinst_o
);

  localparam logic [6:0] OP_LOAD   = 7'b0000011;
  localparam logic [6:0] OP_FLOAD  = 7'b0000111;
  localparam logic [6:0] OP_STORE  = 7'b0100011;
  localparam logic [6:0] OP_FSTORE = 7'b0100111;
  localparam logic [6:0] OP_AMO    = 7'b0101111;
  localparam logic [6:0] OP_SYS    = 7'b1110011;
  localparam logic [2:0] F3_WORD   = 3'b010;
  localparam logic [2:0] F3_DWORD  = 3'b011;
  localparam logic [2:0] F3_HVIRT  = 3'b100;
  localparam logic [4:0] SP_IDX    = 5'd2;
  localparam logic [AW-1:0] ONE    = {{(AW-1){1'b0}}, 1'b1};

  function automatic logic [31:0] ld_form(logic [6:0] opc, logic [2:0] f3, logic [4:0] rd);
    return {12'b0, 5'b0, f3, rd, opc};
  endfunction

  function automatic logic [31:0] st_form(logic [6:0] opc, logic [2:0] f3, logic [4:0] rs2);
    return {7'b0, rs2, 5'b0, f3, 5'b0, opc};
  endfunction

  logic          is_c;
  logic [2:0]    cf3;
  logic [4:0]    rs1_c, reg_c, rd_sp, rs2_sp;
  logic [AW-1:0] imm_cw, imm_cd, imm_lwsp, imm_ldsp, imm_swsp, imm_sdsp, imm_i, imm_s;

  assign is_c   = insn_i[1:0] != 2'b11;
  assign cf3    = insn_i[15:13];
  assign rs1_c  = {2'b01, insn_i[9:7]};
  assign reg_c  = {2'b01, insn_i[4:2]};
  assign rd_sp  = insn_i[11:7];
  assign rs2_sp = insn_i[6:2];

  assign imm_cw   = AW'({insn_i[5], insn_i[12:10], insn_i[6], 2'b00});
  assign imm_cd   = AW'({insn_i[6:5], insn_i[12:10], 3'b000});
  assign imm_lwsp = AW'({insn_i[3:2], insn_i[12], insn_i[6:4], 2'b00});
  assign imm_ldsp = AW'({insn_i[4:2], insn_i[12], insn_i[6:5], 3'b000});
  assign imm_swsp = AW'({insn_i[8:7], insn_i[12:9], 2'b00});
  assign imm_sdsp = AW'({insn_i[9:7], insn_i[12:10], 3'b000});
  assign imm_i    = AW'($signed(insn_i[31:20]));
  assign imm_s    = AW'($signed({insn_i[31:25], insn_i[11:7]}));

  logic [31:0]   xw;
  logic [4:0]    bidx;
  logic [AW-1:0] imm;
  logic [3:0]    szlog;
  logic          sized;

  always_comb begin
    xw    = '0;
    bidx  = '0;
    imm   = '0;
    szlog = '0;
    sized = 1'b0;
    if (is_c) begin
      case (insn_i[1:0])
        2'b00: begin
          case (cf3)
            3'b001: begin
              xw = ld_form(OP_FLOAD, F3_DWORD, reg_c);
              bidx = rs1_c; imm = imm_cd; szlog = 4'd3; sized = 1'b1;
            end
            3'b010: begin
              xw = ld_form(OP_LOAD, F3_WORD, reg_c);
              bidx = rs1_c; imm = imm_cw; szlog = 4'd2; sized = 1'b1;
            end
            3'b011: begin
              bidx = rs1_c; sized = 1'b1;
              if (rv32_i) begin
                xw = ld_form(OP_FLOAD, F3_WORD, reg_c); imm = imm_cw; szlog = 4'd2;
              end else begin
                xw = ld_form(OP_LOAD, F3_DWORD, reg_c); imm = imm_cd; szlog = 4'd3;
              end
            end
            3'b101: begin
              xw = st_form(OP_FSTORE, F3_DWORD, reg_c);
              bidx = rs1_c; imm = imm_cd; szlog = 4'd3; sized = 1'b1;
            end
            3'b110: begin
              xw = st_form(OP_STORE, F3_WORD, reg_c);
              bidx = rs1_c; imm = imm_cw; szlog = 4'd2; sized = 1'b1;
            end
            3'b111: begin
              bidx = rs1_c; sized = 1'b1;
              if (rv32_i) begin
                xw = st_form(OP_FSTORE, F3_WORD, reg_c); imm = imm_cw; szlog = 4'd2;
              end else begin
                xw = st_form(OP_STORE, F3_DWORD, reg_c); imm = imm_cd; szlog = 4'd3;
              end
            end
            default: ;
          endcase
        end
        2'b10: begin
          case (cf3)
            3'b001: begin
              xw = ld_form(OP_FLOAD, F3_DWORD, rd_sp);
              bidx = SP_IDX; imm = imm_ldsp; szlog = 4'd3; sized = 1'b1;
            end
            3'b010: begin
              xw = ld_form(OP_LOAD, F3_WORD, rd_sp);
              bidx = SP_IDX; imm = imm_lwsp; szlog = 4'd2; sized = 1'b1;
            end
            3'b011: begin
              bidx = SP_IDX; sized = 1'b1;
              if (rv32_i) begin
                xw = ld_form(OP_FLOAD, F3_WORD, rd_sp); imm = imm_lwsp; szlog = 4'd2;
              end else begin
                xw = ld_form(OP_LOAD, F3_DWORD, rd_sp); imm = imm_ldsp; szlog = 4'd3;
              end
            end
            3'b101: begin
              xw = st_form(OP_FSTORE, F3_DWORD, rs2_sp);
              bidx = SP_IDX; imm = imm_sdsp; szlog = 4'd3; sized = 1'b1;
            end
            3'b110: begin
              xw = st_form(OP_STORE, F3_WORD, rs2_sp);
              bidx = SP_IDX; imm = imm_swsp; szlog = 4'd2; sized = 1'b1;
            end
            3'b111: begin
              bidx = SP_IDX; sized = 1'b1;
              if (rv32_i) begin
                xw = st_form(OP_FSTORE, F3_WORD, rs2_sp); imm = imm_swsp; szlog = 4'd2;
              end else begin
                xw = st_form(OP_STORE, F3_DWORD, rs2_sp); imm = imm_sdsp; szlog = 4'd3;
              end
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end else begin
      case (insn_i[6:0])
        OP_AMO: begin
          xw = insn_i; bidx = insn_i[19:15];
          szlog = {1'b0, insn_i[14:12]}; sized = 1'b1;
        end
        OP_LOAD, OP_FLOAD: begin
          xw = {12'b0, insn_i[19:0]}; bidx = insn_i[19:15]; imm = imm_i;
          szlog = {1'b0, insn_i[14:12]}; sized = 1'b1;
        end
        OP_STORE, OP_FSTORE: begin
          xw = {7'b0, insn_i[24:12], 5'b0, insn_i[6:0]}; bidx = insn_i[19:15]; imm = imm_s;
          szlog = {1'b0, insn_i[14:12]}; sized = 1'b1;
        end
        OP_SYS: begin
          if (insn_i[14:12] == F3_HVIRT) begin
            xw = insn_i; bidx = insn_i[19:15];
            szlog = 4'd1 << insn_i[27:26]; sized = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  logic [AW-1:0] mask, diff, off;
  logic          unused_hi;

  assign mask      = (ONE << szlog) - ONE;
  assign diff      = fault_addr_i - (base_val_i + imm);
  assign off       = diff & mask;
  assign unused_hi = ^off[AW-1:5];

  assign base_idx_o = bidx;
  assign tinst_o    = {xw[31:20], sized ? off[4:0] : xw[19:15], xw[14:2],
                       is_c ? 1'b0 : xw[1], xw[0]};

  always_comb begin
    // R6
    cmp_bit1_chk: assert (!is_c || tinst_o[1] == 1'b0);
    // R7
    ld_imm_zero_chk: assert (is_c || !(insn_i[6:0] == OP_LOAD || insn_i[6:0] == OP_FLOAD)
                             || tinst_o[31:20] == 12'b0);
    // R8
    st_imm_zero_chk: assert (is_c || !(insn_i[6:0] == OP_STORE || insn_i[6:0] == OP_FSTORE)
                             || (tinst_o[31:25] == 7'b0 && tinst_o[11:7] == 5'b0));
    // R9
    amo_keep_chk: assert (is_c || insn_i[6:0] != OP_AMO
                          || (tinst_o[31:20] == insn_i[31:20] && tinst_o[14:0] == insn_i[14:0]));
    // R11
    byte_off_zero_chk: assert (is_c || insn_i[6:0] != OP_LOAD || insn_i[14:12] != 3'b000
                               || tinst_o[19:15] == 5'b0);
    // R5
    sp_base_chk: assert (insn_i[1:0] != 2'b10 || tinst_o == 32'b0 || base_idx_o == SP_IDX);
    // R1
    q1_zero_chk: assert (insn_i[1:0] != 2'b01 || (tinst_o == 32'b0 && base_idx_o == 5'b0));
  end

endmodule

// File: tb/trap_insn_xform_bench.sv
`timescale 1ns/1ps
module trap_insn_xform_bench;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic [31:0]   insn;
  logic          rv32;
  logic [AW-1:0] fault, base;
  logic [4:0]    bidx;
  logic [31:0]   tinst;
  int            errors = 0;
  int            checks = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  trap_insn_xform #(.AW(AW)) u_trap_insn_xform (
    .insn_i(insn), .rv32_i(rv32), .fault_addr_i(fault), .base_val_i(base),
    .base_idx_o(bidx), .tinst_o(tinst)
  );

  task automatic apply(input logic [31:0] i, input logic m32, input logic [AW-1:0] b,
                       input logic [AW-1:0] f);
    @(posedge clk);
    insn = i; rv32 = m32; base = b; fault = f;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic t_idle;
    apply(32'h0, 1'b0, '0, '0);
    chk("R1 zero word", tinst, 32'h0);
    chk("R1 zero word base", {27'b0, bidx}, 32'h0);
  endtask

  task automatic t_c_word;
    apply(32'h4594, 1'b0, 64'h1000, 64'h100A);
    chk("R2 c.lw", tinst, {12'b0, 5'd2, 3'b010, 5'd13, 7'b0000001});
    chk("R2 c.lw base", {27'b0, bidx}, 32'd11);
    chk("R6 c.lw bit1", {31'b0, tinst[1]}, 32'd0);
    apply(32'hC594, 1'b0, 64'h1000, 64'h1009);
    chk("R2 c.sw", tinst, {7'b0, 5'd13, 5'd1, 3'b010, 5'b0, 7'b0100001});
    chk("R2 c.sw base", {27'b0, bidx}, 32'd11);
  endtask

  task automatic t_c_shared;
    apply(32'h6594, 1'b1, 64'h1000, 64'h100D);
    chk("R3 rv32 flw", tinst, {12'b0, 5'd1, 3'b010, 5'd13, 7'b0000101});
    apply(32'h6594, 1'b0, 64'h1000, 64'h100D);
    chk("R3 rv64 ld", tinst, {12'b0, 5'd5, 3'b011, 5'd13, 7'b0000001});
    apply(32'hE594, 1'b1, 64'h1000, 64'h100D);
    chk("R3 rv32 fsw", tinst, {7'b0, 5'd13, 5'd1, 3'b010, 5'b0, 7'b0100101});
    apply(32'hE594, 1'b0, 64'h1000, 64'h100D);
    chk("R3 rv64 sd", tinst, {7'b0, 5'd13, 5'd5, 3'b011, 5'b0, 7'b0100001});
  endtask

  task automatic t_c_double;
    apply(32'h2594, 1'b1, 64'h1000, 64'h100D);
    chk("R4 c.fld", tinst, {12'b0, 5'd5, 3'b011, 5'd13, 7'b0000101});
    apply(32'hA594, 1'b1, 64'h1000, 64'h100D);
    chk("R4 c.fsd", tinst, {7'b0, 5'd13, 5'd5, 3'b011, 5'b0, 7'b0100101});
  endtask

  task automatic t_c_stack;
    apply(32'h44C2, 1'b0, 64'h2000, 64'h2013);
    chk("R5 c.lwsp", tinst, {12'b0, 5'd3, 3'b010, 5'd9, 7'b0000001});
    chk("R5 c.lwsp base", {27'b0, bidx}, 32'd2);
    apply(32'hE052, 1'b0, 64'h3000, 64'h3006);
    chk("R5 c.sdsp", tinst, {7'b0, 5'd20, 5'd6, 3'b011, 5'b0, 7'b0100001});
    chk("R5 c.sdsp base", {27'b0, bidx}, 32'd2);
    apply(32'hE052, 1'b1, 64'h3000, 64'h3006);
    chk("R3 c.fswsp", tinst, {7'b0, 5'd20, 5'd2, 3'b010, 5'b0, 7'b0100101});
    apply(32'h2482, 1'b0, 64'h3000, 64'h3005);
    chk("R4 c.fldsp", tinst, {12'b0, 5'd5, 3'b011, 5'd9, 7'b0000101});
  endtask

  task automatic t_load32;
    apply(32'h00533283, 1'b0, 64'h100, 64'h108);
    chk("R11 ld imm offset", tinst, {12'b0, 5'd3, 3'b011, 5'd5, 7'b0000011});
    chk("R11 ld base", {27'b0, bidx}, 32'd6);
    apply(32'hFFC12083, 1'b0, 64'h104, 64'h102);
    chk("R7 lw neg imm", tinst, {12'b0, 5'd2, 3'b010, 5'd1, 7'b0000011});
    apply({12'd7, 5'd4, 3'b000, 5'd3, 7'b0000011}, 1'b0, 64'h10, 64'h1F);
    chk("R7 lb byte", tinst, {12'b0, 5'd0, 3'b000, 5'd3, 7'b0000011});
    apply({12'd1, 5'd9, 3'b011, 5'd2, 7'b0000111}, 1'b0, 64'h40, 64'h44);
    chk("R7 fld", tinst, {12'b0, 5'd3, 3'b011, 5'd2, 7'b0000111});
  endtask

  task automatic t_store32;
    apply({7'b0, 5'd7, 5'd8, 3'b011, 5'd9, 7'b0100011}, 1'b0, 64'h200, 64'h20C);
    chk("R8 sd", tinst, {7'b0, 5'd7, 5'd3, 3'b011, 5'b0, 7'b0100011});
    apply({7'h7F, 5'd3, 5'd4, 3'b001, 5'h1F, 7'b0100011}, 1'b0, 64'h10, 64'h10);
    chk("R8 sh neg imm", tinst, {7'b0, 5'd3, 5'd1, 3'b001, 5'b0, 7'b0100011});
    apply({7'h01, 5'd5, 5'd6, 3'b010, 5'd0, 7'b0100111}, 1'b1, 64'h80, 64'hA3);
    chk("R8 fsw", tinst, {7'b0, 5'd5, 5'd3, 3'b010, 5'b0, 7'b0100111});
  endtask

  task automatic t_amo;
    apply({7'h04, 5'd2, 5'd3, 3'b010, 5'd1, 7'b0101111}, 1'b0, 64'h400, 64'h402);
    chk("R9 amo.w", tinst, {7'h04, 5'd2, 5'd2, 3'b010, 5'd1, 7'b0101111});
    chk("R9 amo base", {27'b0, bidx}, 32'd3);
    apply({7'h04, 5'd2, 5'd3, 3'b011, 5'd1, 7'b0101111}, 1'b0, 64'h400, 64'h405);
    chk("R9 amo.d", tinst, {7'h04, 5'd2, 5'd5, 3'b011, 5'd1, 7'b0101111});
  endtask

  task automatic t_hyp;
    apply({7'b0110100, 5'd0, 5'd10, 3'b100, 5'd6, 7'b1110011}, 1'b0, 64'h500, 64'h50B);
    chk("R10 hyp size16", tinst, {7'b0110100, 5'd0, 5'd11, 3'b100, 5'd6, 7'b1110011});
    chk("R10 hyp base", {27'b0, bidx}, 32'd10);
    apply({7'b0110010, 5'd0, 5'd10, 3'b100, 5'd6, 7'b1110011}, 1'b0, 64'h500, 64'h50B);
    chk("R10 hyp size4", tinst, {7'b0110010, 5'd0, 5'd3, 3'b100, 5'd6, 7'b1110011});
    apply({7'b0110000, 5'd0, 5'd10, 3'b100, 5'd6, 7'b1110011}, 1'b0, 64'h500, 64'h50B);
    chk("R10 hyp size2", tinst, {7'b0110000, 5'd0, 5'd1, 3'b100, 5'd6, 7'b1110011});
    apply({7'b0110110, 5'd0, 5'd10, 3'b100, 5'd6, 7'b1110011}, 1'b0, 64'h500, 64'h51D);
    chk("R10 hyp size256", tinst, {7'b0110110, 5'd0, 5'd29, 3'b100, 5'd6, 7'b1110011});
  endtask

  task automatic t_other;
    apply(32'h4501, 1'b0, 64'h100, 64'h103);
    chk("R1 quadrant1", tinst, 32'h0);
    chk("R1 quadrant1 base", {27'b0, bidx}, 32'h0);
    apply(32'h0040, 1'b0, 64'h100, 64'h103);
    chk("R1 q0 unlisted", tinst, 32'h0);
    apply(32'h8082, 1'b0, 64'h100, 64'h103);
    chk("R1 q2 unlisted", tinst, 32'h0);
    apply({7'b0, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011}, 1'b0, 64'h100, 64'h103);
    chk("R12 alu op", tinst, 32'h0);
    apply({12'h300, 5'd1, 3'b001, 5'd0, 7'b1110011}, 1'b0, 64'h100, 64'h103);
    chk("R12 csr op", tinst, 32'h0);
  endtask

  initial begin
    insn = '0; rv32 = 1'b0; base = '0; fault = '0;
    t_idle();
    t_c_word();
    t_c_shared();
    t_c_double();
    t_c_stack();
    t_load32();
    t_store32();
    t_amo();
    t_hyp();
    t_other();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule